// File: doc/BRIEF.md
# Frequency-Locked Oscillator Trim Controller

This block closes the digital control loop of a clock generator built around a tunable ring oscillator. It counts oscillator cycles over a window of reference-clock cycles and compares the count with a programmed target. At the end of each window it moves a delay-step count by at most one: up when the oscillator runs fast, down when it runs slow, and not at all inside a tolerance band. The step count is expanded into a 26-bit trim word that enables delay stages in the oscillator. Each enabled stage adds roughly 250 ps to a base delay of about 4.67 ns, so more ones mean a slower clock.

The trim word is not a plain thermometer code. Its stages come in two banks of 13. A stage in the upper bank bypasses its partner in the lower bank, so every upper-bank bit is switched on before any lower-bank bit. Within each bank the bits are switched on in an interleaved order that alternates across the ring, so that equal step counts give equal delay. In free-running mode the loop is bypassed, and the oscillator takes its trim word from a manual register that software writes. A second output divides the oscillator clock by a selectable integer from 1 to 8.

Top module: `fll_trim_ctrl`

## Requirements
- R1: During and after reset the manual trim register holds 26'h3FFEFFF (all 13 upper-bank bits and 12 lower-bank bits, bit 12 clear), free-running mode is active so `trim` shows that value, and `locked` is 0.
- R2: A `man_wr` pulse loads `man_wdata` into the manual register in either mode. In free-running mode (`lock_en` = 0), `trim` equals the register one reference cycle after the write. In locked mode a write leaves `trim` unchanged.
- R3: In locked mode `trim` encodes step count n as follows. Bits 25..13 form the upper bank and bits 12..0 the lower bank. The j-th upper bit enabled (j = 0..12) is bit 13 + ((7*j + 6) mod 13). Once all 13 upper bits are on, the j-th lower bit enabled is bit (7*j + 6) mod 13. The word therefore has exactly n ones, and no lower-bank bit is set unless the upper bank is full.
- R4: The step count stays within 0..26. It saturates at 26 (trim 26'h3FFFFFF) and at 0 (trim 0) and does not wrap.
- R5: At each window end in locked mode, let C be the oscillator cycles counted in the window and T the target. If C > T + tolerance, the step count rises by one. If C + tolerance < T, it falls by one. Otherwise it holds.
- R6: A measurement window lasts `win_len` reference cycles (`win_len` >= 2), so successive step changes are exactly `win_len` reference periods apart.
- R7: On the first reference cycle with `lock_en` high after free-running mode, the step count is loaded with the number of ones in the manual register. `trim` then shows the R3 code for that count.
- R8: `locked` rises once the step count has stayed unchanged for `lock_windows` consecutive windows. Any change of the step count clears it, and it is 0 in free-running mode.
- R9: `clk_div` has one rising edge for every `div_sel` + 1 rising edges of `osc_clk`.
- R10: A new `div_sel` value is taken up only when the divider counter wraps, so the division ratio changes only at a divided-clock boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; clocks the loop and the manual register |
| osc_clk | input | 1 | Clock from the controlled oscillator |
| rst | input | 1 | Synchronous active-high reset, sampled in both clock domains |
| lock_en | input | 1 | 1 selects locked mode, 0 selects free-running mode |
| man_wr | input | 1 | Write strobe for the manual trim register |
| man_wdata | input | 26 | Value to load into the manual trim register |
| target | input | 16 | Expected oscillator cycles per window |
| tolerance | input | 8 | Half-width of the hold band around the target |
| win_len | input | 8 | Window length in reference cycles |
| lock_windows | input | 8 | Number of unchanged windows required before `locked` rises |
| div_sel | input | 3 | Division ratio minus one |
| trim | output | 26 | Trim word sent to the oscillator |
| locked | output | 1 | Lock indicator |
| clk_div | output | 1 | Divided oscillator clock |

## Verification
The assertions assume several things about the inputs. The configuration fields change only between measurements, and `win_len` is at least 2. A window holds fewer than 65536 oscillator cycles, so the Gray-coded counter difference never wraps. Reset is held for several cycles of both clocks, and `div_sel` is held long enough to pass its synchronizer. The stimulus meets these limits: it changes `target`, `tolerance` and `win_len` only on falling reference edges in a settled state, and it keeps the window at 8 or 16 reference periods, where at most about 70 oscillator cycles fit. It also waits dozens of oscillator cycles after every ratio change before it counts edges.

// File: rtl/fll_pkg.sv
package fll_pkg;

    localparam int GROUP_LEN     = 13;
    localparam int TRIM_W        = 2 * GROUP_LEN;
    localparam int STEP_MAX      = TRIM_W;
    localparam int STEP_W        = $clog2(STEP_MAX + 1);
    // interleave stride/offset: alternate stages across the ring
    localparam int SPREAD_STRIDE = GROUP_LEN / 2 + 1;
    localparam int SPREAD_START  = GROUP_LEN / 2;
    localparam logic [TRIM_W-1:0] TRIM_RESET = 26'h3FFEFFF;

    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic [1:0] {
        ADJ_HOLD   = 2'd0,
        ADJ_SLOWER = 2'd1,
        ADJ_FASTER = 2'd2
    } adj_e;

    typedef struct packed {
        logic win_end;
        adj_e adj;
    } verdict_t;

    // position in the enable order of bank bit 'pos'
    function automatic int fill_rank(int pos);
        int r;
        r = 0;
        for (int j = 0; j < GROUP_LEN; j++) begin
            if (((SPREAD_STRIDE * j + SPREAD_START) % GROUP_LEN) == pos) r = j;
        end
        return r;
    endfunction

    function automatic step_t count_ones(logic [TRIM_W-1:0] w);
        int s;
        s = 0;
        for (int i = 0; i < TRIM_W; i++) s += int'(w[i]);
        return step_t'(s);
    endfunction

endpackage

// File: rtl/fll_trim_enc.sv
module fll_trim_enc
    import fll_pkg::*;
(
    input  step_t             step,
    output logic [TRIM_W-1:0] trim_word
);

    // upper bank fills first (it bypasses the lower bank), each bank interleaved
    for (genvar b = 0; b < GROUP_LEN; b++) begin : g_bit
        localparam int RANK = fill_rank(b);
        assign trim_word[GROUP_LEN + b] = (int'(step) > RANK);
        assign trim_word[b]             = (int'(step) > GROUP_LEN + RANK);
    end

endmodule

// File: rtl/fll_cnt_xfer.sv
module fll_cnt_xfer #(
    parameter int CNT_W = 16
) (
    input  logic             osc_clk,
    input  logic             ref_clk,
    input  logic             rst,
    output logic [CNT_W-1:0] ref_count
);

    logic [CNT_W-1:0] bin_q, bin_nxt, gray_q;
    logic [CNT_W-1:0] sync1_q, sync2_q, bin_r;

    assign bin_nxt = bin_q + CNT_W'(1);

    always_ff @(posedge osc_clk) begin
        if (rst) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_nxt;
            gray_q <= bin_nxt ^ (bin_nxt >> 1);
        end
    end

    always_ff @(posedge ref_clk) begin
        if (rst) begin
            sync1_q   <= '0;
            sync2_q   <= '0;
            ref_count <= '0;
        end else begin
            sync1_q   <= gray_q;
            sync2_q   <= sync1_q;
            ref_count <= bin_r;
        end
    end

    always_comb begin
        bin_r[CNT_W-1] = sync2_q[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) bin_r[i] = bin_r[i+1] ^ sync2_q[i];
    end

    // only one bit may move per oscillator cycle for a safe crossing (R6)
    assert_gray_single_R6: assert property (@(posedge osc_clk) disable iff (rst)
        $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/fll_loop.sv
module fll_loop
    import fll_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int TOL_W  = 8,
    parameter int WIN_W  = 8,
    parameter int LOCK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock_en,
    input  logic              man_wr,
    input  logic [TRIM_W-1:0] man_wdata,
    input  logic [CNT_W-1:0]  osc_count,
    input  logic [CNT_W-1:0]  target,
    input  logic [TOL_W-1:0]  tolerance,
    input  logic [WIN_W-1:0]  win_len,
    input  logic [LOCK_W-1:0] lock_windows,
    output logic              lock_mode,
    output logic [TRIM_W-1:0] man_word,
    output step_t             step,
    output logic              locked
);

    localparam int    CMP_W = CNT_W + 1;
    localparam step_t TOP   = step_t'(STEP_MAX);

    logic [TRIM_W-1:0] man_q;
    logic              mode_q;
    logic [WIN_W-1:0]  win_q;
    logic [CNT_W-1:0]  base_q;
    step_t             step_q, step_nxt;
    logic [LOCK_W-1:0] stable_q, stable_nxt;
    logic              locked_q;

    logic [CNT_W-1:0]  meas;
    logic [CMP_W-1:0]  meas_x, hi_lim, lo_sum, tgt_x;
    verdict_t          v;

    always_comb begin
        meas      = osc_count - base_q;
        meas_x    = {1'b0, meas};
        tgt_x     = {1'b0, target};
        hi_lim    = tgt_x + CMP_W'(tolerance);
        lo_sum    = meas_x + CMP_W'(tolerance);
        v.win_end = (win_q >= win_len - WIN_W'(1));
        if (meas_x > hi_lim)     v.adj = ADJ_SLOWER;
        else if (lo_sum < tgt_x) v.adj = ADJ_FASTER;
        else                     v.adj = ADJ_HOLD;

        step_nxt = step_q;
        case (v.adj)
            ADJ_SLOWER: if (step_q != TOP) step_nxt = step_q + step_t'(1);
            ADJ_FASTER: if (step_q != '0)  step_nxt = step_q - step_t'(1);
            default:    step_nxt = step_q;
        endcase

        stable_nxt = (stable_q == '1) ? stable_q : stable_q + LOCK_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            man_q    <= TRIM_RESET;
            mode_q   <= 1'b0;
            win_q    <= '0;
            base_q   <= '0;
            step_q   <= count_ones(TRIM_RESET);
            stable_q <= '0;
            locked_q <= 1'b0;
        end else begin
            if (man_wr) man_q <= man_wdata;
            mode_q <= lock_en;
            if (!lock_en) begin
                win_q    <= '0;
                base_q   <= osc_count;
                stable_q <= '0;
                locked_q <= 1'b0;
            end else if (!mode_q) begin
                step_q   <= count_ones(man_q);
                win_q    <= '0;
                base_q   <= osc_count;
                stable_q <= '0;
                locked_q <= 1'b0;
            end else if (v.win_end) begin
                win_q  <= '0;
                base_q <= osc_count;
                step_q <= step_nxt;
                if (step_nxt != step_q) begin
                    stable_q <= '0;
                    locked_q <= 1'b0;
                end else begin
                    stable_q <= stable_nxt;
                    locked_q <= (stable_nxt >= lock_windows);
                end
            end else begin
                win_q <= win_q + WIN_W'(1);
            end
        end
    end

    assign lock_mode = mode_q;
    assign man_word  = man_q;
    assign step      = step_q;
    assign locked    = locked_q;

    assert_step_range_R4: assert property (@(posedge clk) disable iff (rst)
        int'(step_q) <= STEP_MAX);

    assert_single_move_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q && $past(mode_q)) |->
        (step_q == $past(step_q) || int'(step_q) == int'($past(step_q)) + 1
         || int'(step_q) + 1 == int'($past(step_q))));

    assert_seed_count_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_q) |-> (step_q == count_ones($past(man_q))));

    assert_change_unlocks_R8: assert property (@(posedge clk) disable iff (rst)
        (step_q != $past(step_q)) |-> !locked_q);

    assert_free_unlocked_R8: assert property (@(posedge clk) disable iff (rst)
        !mode_q |-> !locked_q);

endmodule

// File: rtl/fll_clk_div.sv
module fll_clk_div #(
    parameter int SEL_W = 3
) (
    input  logic             osc_clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] div_sel,
    output logic             clk_div
);

    localparam int RAT_W = SEL_W + 1;

    logic [SEL_W-1:0] sel1_q, sel2_q, cnt_q, cnt_nxt;
    logic [RAT_W-1:0] ratio_q, ratio_nxt;
    logic             wrap, high_nxt;
    logic             div_q, bypass_q, bypass_n_q;

    always_comb begin
        wrap      = ({1'b0, cnt_q} == ratio_q - RAT_W'(1));
        ratio_nxt = wrap ? ({1'b0, sel2_q} + RAT_W'(1)) : ratio_q;
        cnt_nxt   = wrap ? '0 : cnt_q + SEL_W'(1);
        high_nxt  = (ratio_nxt != RAT_W'(1)) && ({1'b0, cnt_nxt} < (ratio_nxt >> 1));
    end

    always_ff @(posedge osc_clk) begin
        if (rst) begin
            sel1_q   <= '0;
            sel2_q   <= '0;
            ratio_q  <= RAT_W'(1);
            cnt_q    <= '0;
            div_q    <= 1'b0;
            bypass_q <= 1'b1;
        end else begin
            sel1_q   <= div_sel;
            sel2_q   <= sel1_q;
            ratio_q  <= ratio_nxt;
            cnt_q    <= cnt_nxt;
            div_q    <= high_nxt;
            bypass_q <= (ratio_nxt == RAT_W'(1));
        end
    end

    // bypass gate moves only while the oscillator clock is low
    always_ff @(negedge osc_clk) begin
        if (rst) bypass_n_q <= 1'b1;
        else     bypass_n_q <= bypass_q;
    end

    assign clk_div = (osc_clk & bypass_n_q) | div_q;

    assert_count_bound_R9: assert property (@(posedge osc_clk) disable iff (rst)
        {1'b0, cnt_q} < ratio_q);

    assert_ratio_at_boundary_R10: assert property (@(posedge osc_clk) disable iff (rst)
        !$stable(ratio_q) |-> (cnt_q == '0));

endmodule

// File: rtl/fll_trim_ctrl.sv
module fll_trim_ctrl
    import fll_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int TOL_W  = 8,
    parameter int WIN_W  = 8,
    parameter int LOCK_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic              ref_clk,
    input  logic              osc_clk,
    input  logic              rst,
    input  logic              lock_en,
    input  logic              man_wr,
    input  logic [TRIM_W-1:0] man_wdata,
    input  logic [CNT_W-1:0]  target,
    input  logic [TOL_W-1:0]  tolerance,
    input  logic [WIN_W-1:0]  win_len,
    input  logic [LOCK_W-1:0] lock_windows,
    input  logic [SEL_W-1:0]  div_sel,
    output logic [TRIM_W-1:0] trim,
    output logic              locked,
    output logic              clk_div
);

    logic [CNT_W-1:0]  osc_count;
    logic              lock_mode;
    logic [TRIM_W-1:0] man_word, enc_word;
    step_t             step;

    fll_cnt_xfer #(.CNT_W(CNT_W)) u_xfer (
        .osc_clk   (osc_clk),
        .ref_clk   (ref_clk),
        .rst       (rst),
        .ref_count (osc_count)
    );

    fll_loop #(
        .CNT_W(CNT_W), .TOL_W(TOL_W), .WIN_W(WIN_W), .LOCK_W(LOCK_W)
    ) u_loop (
        .clk          (ref_clk),
        .rst          (rst),
        .lock_en      (lock_en),
        .man_wr       (man_wr),
        .man_wdata    (man_wdata),
        .osc_count    (osc_count),
        .target       (target),
        .tolerance    (tolerance),
        .win_len      (win_len),
        .lock_windows (lock_windows),
        .lock_mode    (lock_mode),
        .man_word     (man_word),
        .step         (step),
        .locked       (locked)
    );

    fll_trim_enc u_enc (
        .step      (step),
        .trim_word (enc_word)
    );

    fll_clk_div #(.SEL_W(SEL_W)) u_div (
        .osc_clk (osc_clk),
        .rst     (rst),
        .div_sel (div_sel),
        .clk_div (clk_div)
    );

    assign trim = lock_mode ? enc_word : man_word;

    assert_bank_order_R3: assert property (@(posedge ref_clk) disable iff (rst)
        (|enc_word[GROUP_LEN-1:0]) |-> (&enc_word[TRIM_W-1:GROUP_LEN]));

    assert_code_weight_R3: assert property (@(posedge ref_clk) disable iff (rst)
        $countones(enc_word) == int'(step));

endmodule

// File: tb/test_fll_trim_ctrl.sv
module test_fll_trim_ctrl;

    // all delays in ps
    localparam int REF_PERIOD = 20000;
    localparam int BASE_PS    = 4670;
    localparam int STEP_PS    = 250;
    localparam int WATCHDOG   = 150000 * REF_PERIOD;
    localparam int N_LOCK     = 4;
    // stimulus/expected vectors: target, tolerance, expected locked
    localparam int LOCK_TAB [N_LOCK][3] = '{'{45, 2, 1}, '{35, 2, 1}, '{60, 2, 1}, '{50, 2, 1}};

    logic        ref_clk = 1'b0;
    logic        osc_clk = 1'b0;
    logic        rst = 1'b1;
    logic        lock_en = 1'b0;
    logic        man_wr = 1'b0;
    logic [25:0] man_wdata = '0;
    logic [15:0] target = 16'd45;
    logic [7:0]  tolerance = 8'd2;
    logic [7:0]  win_len = 8'd16;
    logic [7:0]  lock_windows = 8'd4;
    logic [2:0]  div_sel = 3'd0;
    logic [25:0] trim;
    logic        locked;
    logic        clk_div;

    int checks = 0;
    int fails  = 0;
    int div_edges = 0;

    fll_trim_ctrl i_fll_trim_ctrl (
        .ref_clk(ref_clk), .osc_clk(osc_clk), .rst(rst), .lock_en(lock_en),
        .man_wr(man_wr), .man_wdata(man_wdata), .target(target),
        .tolerance(tolerance), .win_len(win_len), .lock_windows(lock_windows),
        .div_sel(div_sel), .trim(trim), .locked(locked), .clk_div(clk_div)
    );

    always #(REF_PERIOD / 2) ref_clk = ~ref_clk;

    // behavioural ring oscillator: period follows the number of enabled stages
    always begin : osc_model
        int half;
        half = (BASE_PS + STEP_PS * $countones(trim)) / 2;
        #(half) osc_clk = ~osc_clk;
    end

    always @(posedge clk_div) div_edges++;

    function automatic logic [25:0] exp_trim(int n);
        logic [25:0] w;
        w = '0;
        for (int j = 0; j < n; j++) begin
            if (j < 13) w[13 + ((7 * j + 6) % 13)] = 1'b1;
            else        w[(7 * (j - 13) + 6) % 13] = 1'b1;
        end
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic ref_cycles(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic write_man(input logic [25:0] d);
        @(negedge ref_clk);
        man_wr = 1'b1;
        man_wdata = d;
        @(negedge ref_clk);
        man_wr = 1'b0;
    endtask

    initial begin : watchdog
        #(WATCHDOG);
        fails++;
        $display("FAIL watchdog (R1..R10 run) actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        time t0, t1;
        int  p0, p1, d0, d1, pop;
        real ideal;
        bit  ok;

        ref_cycles(6);
        rst = 1'b0;
        ref_cycles(1);
        // R1 reset state
        check(trim == 26'h3FFEFFF, "R1", "trim after reset", 32'(trim), 32'h3FFEFFF);
        check(locked == 1'b0, "R1", "locked after reset", 32'(locked), 0);

        // R2 free-running write
        write_man(26'h0001234);
        check(trim == 26'h0001234, "R2", "free trim follows write", 32'(trim), 32'h0001234);

        // R7 seed from 7 ones, wide tolerance so the loop holds
        write_man(26'h000007F);
        tolerance = 8'd255;
        lock_en = 1'b1;
        ref_cycles(1);
        check(trim == exp_trim(7), "R7", "seeded trim", 32'(trim), 32'(exp_trim(7)));
        ref_cycles(48);
        check(trim == exp_trim(7), "R5", "hold inside band", 32'(trim), 32'(exp_trim(7)));
        write_man(26'h3FFFFFF);
        ref_cycles(1);
        check(trim == exp_trim(7), "R2", "write ignored while locked", 32'(trim), 32'(exp_trim(7)));
        ref_cycles(60);
        check(locked == 1'b1, "R8", "locked after stable windows", 32'(locked), 1);

        // R6 window length and R5 single step upward
        win_len = 8'd8;
        tolerance = 8'd0;
        target = 16'd0;
        @(trim);
        t0 = $time;
        #1 p0 = $countones(trim);
        @(trim);
        t1 = $time;
        #1 p1 = $countones(trim);
        check((t1 - t0) == 8 * REF_PERIOD, "R6", "window spacing ps", 32'(t1 - t0), 32'(8 * REF_PERIOD));
        check(p1 == p0 + 1, "R5", "one step per window up", 32'(p1), 32'(p0 + 1));

        // R4 saturate at top
        ref_cycles(8 * 30);
        check(trim == 26'h3FFFFFF, "R4", "top saturation", 32'(trim), 32'h3FFFFFF);
        ref_cycles(8 * 3);
        check(trim == 26'h3FFFFFF, "R4", "no wrap above 26", 32'(trim), 32'h3FFFFFF);

        // R4 saturate at bottom
        target = 16'hFFFF;
        ref_cycles(8 * 30);
        check(trim == 26'h0, "R4", "bottom saturation", 32'(trim), 0);

        // table walk: R5 convergence, R3 code shape, R8 lock/unlock
        win_len = 8'd16;
        for (int k = 0; k < N_LOCK; k++) begin
            target    = 16'(LOCK_TAB[k][0]);
            tolerance = 8'(LOCK_TAB[k][1]);
            ref_cycles(32);
            check(locked == 1'b0, "R8", "locked cleared by step change", 32'(locked), 0);
            ref_cycles(16 * 45);
            check(locked == 1'(LOCK_TAB[k][2]), "R8", "locked after settling", 32'(locked), 32'(LOCK_TAB[k][2]));
            pop = $countones(trim);
            ideal = real'(16 * REF_PERIOD) / real'(BASE_PS + STEP_PS * pop);
            ok = (ideal - real'(LOCK_TAB[k][0])) <= real'(LOCK_TAB[k][1] + 1)
              && (real'(LOCK_TAB[k][0]) - ideal) <= real'(LOCK_TAB[k][1] + 1);
            check(ok, "R5", "converged step count", 32'(pop), 32'(LOCK_TAB[k][0]));
            check(trim == exp_trim(pop), "R3", "bank order and interleave", 32'(trim), 32'(exp_trim(pop)));
        end

        // back to free-running
        lock_en = 1'b0;
        ref_cycles(2);
        check(trim == 26'h3FFFFFF, "R2", "free mode shows last write", 32'(trim), 32'h3FFFFFF);
        check(locked == 1'b0, "R8", "unlocked in free mode", 32'(locked), 0);

        // R9/R10 divider ratios 1..8
        for (int r = 1; r <= 8; r++) begin
            div_sel = 3'(r - 1);
            repeat (30) @(posedge osc_clk);
            #1 d0 = div_edges;
            repeat (840) @(posedge osc_clk);
            #1 d1 = div_edges;
            check((d1 - d0) == 840 / r, r == 1 ? "R9" : "R10", "divided edges in 840 cycles",
                  32'(d1 - d0), 32'(840 / r));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule